// File: doc/BRIEF.md
# Multi-Format Audio Serial Transmitter

This block is the transmit side of a three-wire stereo audio link (bit clock, word select, serial data) acting as the link master. It divides the system clock down to a bit clock, builds each frame from a left and a right sample, and drives word select and data on the falling bit-clock edge so that a receiver can sample on the rising edge. A 2-bit standard selector picks one of four framings: Philips-style (data one bit behind word select), MSB-aligned, LSB-aligned (right-justified) and PCM (short frame-sync pulse). A 2-bit packing selector picks the slot width and sample width. Unused slot bits are sent as zero.

Samples arrive through a 16-bit write port. Narrow samples take one write per channel. Wide samples take two writes per channel, upper half first. A `ready` output tells the producer when the next 16-bit word can be accepted. A complete frame (left and right) is held until the serializer takes it at the frame boundary. If the held frame is incomplete when a frame starts, zeros are sent and a sticky underrun flag is raised; the next accepted write clears it.

Three state machines make up the block:

- **Bit-clock phase machine** (states `PH_LOW`, `PH_HIGH`). Each state lasts `HALF_DIV` system clocks. `PH_LOW`→`PH_HIGH` is the rising edge. `PH_HIGH`→`PH_LOW` is the falling edge, and it is the launch tick.
- **Write loader** (states `LD_L_HI`, `LD_L_LO`, `LD_R_HI`, `LD_R_LO`, `LD_FULL`). Its transitions are:
  - On an accepted write: `LD_L_HI`→`LD_L_LO` for wide packings, or `LD_L_HI`→`LD_R_HI` for narrow packings.
  - On an accepted write: `LD_L_LO`→`LD_R_HI`.
  - On an accepted write: `LD_R_HI`→`LD_R_LO` for wide packings, or `LD_R_HI`→`LD_FULL` for narrow packings.
  - On an accepted write: `LD_R_LO`→`LD_FULL`.
  - On the frame-start tick: `LD_FULL`→`LD_L_HI`.
- **Slot position counter** in the serializer. It wraps from the last bit of the frame to 0, and that wrap is the frame-start tick.

Top module: `audio_ser_tx`

## Requirements
- R1: For standards 0, 1 and 2, the left slot is sent first with `ws`=0, then the right slot with `ws`=1.
- R2: Every sample goes out MSB first. `sd` and `ws` change only on the falling-edge tick of `bclk` and are stable from one falling edge to the next.
- R3: The packing code `pack_sel` selects:
  - 0: 16-bit data in a 16-bit slot.
  - 1: 16-bit data in a 32-bit slot.
  - 2: 24-bit data in a 32-bit slot.
  - 3: 32-bit data in a 32-bit slot.
  
  Slot bits beyond the data width are sent as 0.
- R4: Standard 0 (Philips-style) sends the MSB-aligned bit stream delayed by one bit period, so `ws` changes one bit before the new channel's MSB. Before any data has been sent, the delayed bit is 0.
- R5: Standard 1 (MSB-aligned) sends each slot's MSB in the same bit period in which `ws` changes.
- R6: Standard 2 (LSB-aligned) right-justifies the data in its slot: leading bits are 0 and the LSB is the last bit of the slot.
- R7: Standard 3 (PCM) sends the left slot then the right slot back to back. `ws` is 1 for exactly the last bit period of each frame and 0 otherwise.
- R8: Write order and flow control:
  - Packings 0 and 1 take one write per channel. Packings 2 and 3 take two writes per channel, upper 16 bits first.
  - For packing 2, the low byte of the second write is discarded.
  - Writes go left then right.
  - `ready` is 1 while the loader can accept a word. It falls the cycle after the last word of a frame, rises again at the next frame start, and writes made while it is 0 have no effect.
- R9: If the frame is not complete at a frame start, that frame is sent as zeros and `underrun` becomes 1 and stays 1 until a write is accepted.
- R10: `bclk` has a period of 2·`HALF_DIV` system clocks with 50% duty. During reset, `bclk`, `ws`, `sd` and `underrun` are 0 and `ready` is 1. The first falling edge after reset starts frame 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| std_sel | input | 2 | Framing standard: 0 Philips, 1 MSB-aligned, 2 LSB-aligned, 3 PCM (hold stable while running) |
| pack_sel | input | 2 | Packing code per R3 (hold stable while running) |
| wr_en | input | 1 | Write strobe for one 16-bit word |
| wr_data | input | 16 | Sample word |
| ready | output | 1 | Loader can accept a word this cycle |
| underrun | output | 1 | Sticky: a frame started without complete data |
| bclk | output | 1 | Bit clock |
| ws | output | 1 | Word select / frame sync |
| sd | output | 1 | Serial data |

## Verification
A write offered at a falling system-clock edge is taken at the next rising edge. `ready` drops on the edge that takes a frame's last word and is read at the following falling edge. Word select and data are launched on the falling-bit-clock tick and are read at the next rising `bclk` edge, half a bit period later, which is where a receiver samples. The rising-edge records are numbered from reset, so record k+1 holds stream bit k. The underrun flag is set by the frame-start tick, and it is checked once the first bit of that frame has been recorded, several system clocks after it has settled. The flag's clearing is checked one system clock after the clearing write.

// File: rtl/audio_tx_pkg.sv
package audio_tx_pkg;

    localparam int WORD_W  = 16;
    localparam int SLOT_W  = 32;
    localparam int POS_W   = $clog2(2 * SLOT_W);

    typedef enum logic [1:0] {
        STD_PHILIPS = 2'd0,
        STD_MSB     = 2'd1,
        STD_LSB     = 2'd2,
        STD_PCM     = 2'd3
    } std_e;

    typedef enum logic [1:0] {
        PK_16_16 = 2'd0,
        PK_16_32 = 2'd1,
        PK_24_32 = 2'd2,
        PK_32_32 = 2'd3
    } pack_e;

    typedef enum logic [2:0] {
        LD_L_HI,
        LD_L_LO,
        LD_R_HI,
        LD_R_LO,
        LD_FULL
    } ld_state_e;

    typedef enum logic {
        PH_LOW,
        PH_HIGH
    } phase_e;

    function automatic logic [POS_W-1:0] slot_bits(pack_e pk);
        return (pk == PK_16_16) ? POS_W'(16) : POS_W'(SLOT_W);
    endfunction

    function automatic logic [POS_W-1:0] data_bits(pack_e pk);
        unique case (pk)
            PK_16_16, PK_16_32: return POS_W'(16);
            PK_24_32:           return POS_W'(24);
            default:            return POS_W'(SLOT_W);
        endcase
    endfunction

    function automatic logic two_words(pack_e pk);
        return (pk == PK_24_32) || (pk == PK_32_32);
    endfunction

endpackage

// File: rtl/bclk_gen.sv
module bclk_gen
    import audio_tx_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic bclk,
    output logic fall_tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] TERM = CW'(HALF_DIV - 1);

    phase_e         phase_q, phase_d;
    logic [CW-1:0]  cnt_q;
    logic           term;

    assign term = (cnt_q == TERM);

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_LOW:  if (term) phase_d = PH_HIGH;
            PH_HIGH: if (term) phase_d = PH_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_LOW;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= term ? '0 : cnt_q + 1'b1;
        end
    end

    always_comb begin
        bclk      = (phase_q == PH_HIGH);
        fall_tick = (phase_q == PH_HIGH) && term;
    end

endmodule

// File: rtl/sample_loader.sv
module sample_loader
    import audio_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  pack_e             pack,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              frame_start,
    output logic              ready,
    output logic              full,
    output logic              underrun,
    output logic [SLOT_W-1:0] left_smp,
    output logic [SLOT_W-1:0] right_smp
);
    ld_state_e state_q, state_d;
    logic      accept;
    logic      wide;
    logic      starve;

    assign wide   = two_words(pack);
    assign accept = wr_en && (state_q != LD_FULL);
    assign starve = frame_start && (state_q != LD_FULL);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LD_L_HI: if (accept) state_d = wide ? LD_L_LO : LD_R_HI;
            LD_L_LO: if (accept) state_d = LD_R_HI;
            LD_R_HI: if (accept) state_d = wide ? LD_R_LO : LD_FULL;
            LD_R_LO: if (accept) state_d = LD_FULL;
            LD_FULL: if (frame_start) state_d = LD_L_HI;
            default: state_d = LD_L_HI;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= LD_L_HI;
            left_smp  <= '0;
            right_smp <= '0;
            underrun  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                unique case (state_q)
                    LD_L_HI: left_smp  <= {wr_data, {(SLOT_W-WORD_W){1'b0}}};
                    LD_L_LO: left_smp[WORD_W-1:0]  <= wr_data;
                    LD_R_HI: right_smp <= {wr_data, {(SLOT_W-WORD_W){1'b0}}};
                    LD_R_LO: right_smp[WORD_W-1:0] <= wr_data;
                    default: ;
                endcase
            end
            if (starve)
                underrun <= 1'b1;
            else if (accept)
                underrun <= 1'b0;
        end
    end

    always_comb begin
        ready = (state_q != LD_FULL);
        full  = (state_q == LD_FULL);
    end

    assert_full_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && state_d == LD_FULL && !frame_start) |=> !ready)
        else $error("ready still high after last word of frame");

    assert_start_frees_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && full) |=> ready)
        else $error("ready not restored at frame start");

    assert_underrun_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        starve |=> underrun)
        else $error("underrun not raised on incomplete frame");

    assert_underrun_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !frame_start) |=> !underrun)
        else $error("underrun not cleared by write");

endmodule

// File: rtl/slot_serializer.sv
module slot_serializer
    import audio_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  std_e              std,
    input  pack_e             pack,
    input  logic              fall_tick,
    input  logic              full,
    input  logic [SLOT_W-1:0] left_smp,
    input  logic [SLOT_W-1:0] right_smp,
    output logic              frame_start,
    output logic              ws,
    output logic              sd
);
    logic [POS_W-1:0]  pos_q, nxt, slot, dbits, last, p, off;
    logic [POS_W:0]    two_s;
    logic [SLOT_W-1:0] cur_l, cur_r, src_l, src_r, v;
    logic [4:0]        idx_m, idx_l;
    logic              ch, raw, dly_q, ws_d, sd_d;

    always_comb begin
        slot  = slot_bits(pack);
        dbits = data_bits(pack);
        two_s = {slot, 1'b0};
        last  = POS_W'(two_s - 1'b1);
        nxt   = (pos_q >= last) ? '0 : pos_q + 1'b1;
        frame_start = fall_tick && (nxt == '0);
        src_l = (nxt == '0) ? (full ? left_smp  : '0) : cur_l;
        src_r = (nxt == '0) ? (full ? right_smp : '0) : cur_r;
        ch    = (nxt >= slot);
        p     = ch ? nxt - slot : nxt;
        v     = ch ? src_r : src_l;
        off   = slot - dbits;
        idx_m = 5'(POS_W'(SLOT_W - 1) - p);
        idx_l = 5'(POS_W'(SLOT_W - 1) - (p - off));
        if (std == STD_LSB)
            raw = (p >= off) && v[idx_l];
        else
            raw = (p < dbits) && v[idx_m];
        ws_d = (std == STD_PCM) ? (nxt == last) : ch;
        sd_d = (std == STD_PHILIPS) ? dly_q : raw;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '1;
            cur_l <= '0;
            cur_r <= '0;
            dly_q <= 1'b0;
            ws    <= 1'b0;
            sd    <= 1'b0;
        end else if (fall_tick) begin
            pos_q <= nxt;
            if (nxt == '0) begin
                cur_l <= src_l;
                cur_r <= src_r;
            end
            dly_q <= raw;
            ws    <= ws_d;
            sd    <= sd_d;
        end
    end

    assert_launch_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_tick |=> ($stable(sd) && $stable(ws)))
        else $error("serial outputs moved away from falling edge");

    assert_pcm_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (std == STD_PCM && ws && fall_tick) |=> !ws)
        else $error("PCM sync longer than one bit");

    assert_pad_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_tick && std == STD_MSB && p >= dbits) |=> !sd)
        else $error("padding bit not zero");

    assert_ws_at_frame_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && std != STD_PCM) |=> !ws)
        else $error("frame does not start on left channel");

endmodule

// File: rtl/audio_ser_tx.sv
module audio_ser_tx
    import audio_tx_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  std_sel,
    input  logic [1:0]  pack_sel,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    output logic        ready,
    output logic        underrun,
    output logic        bclk,
    output logic        ws,
    output logic        sd
);
    logic              fall_tick, frame_start, full;
    logic [SLOT_W-1:0] left_smp, right_smp;
    std_e              std;
    pack_e             pack;

    assign std  = std_e'(std_sel);
    assign pack = pack_e'(pack_sel);

    bclk_gen #(.HALF_DIV(HALF_DIV)) u_bclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk      (bclk),
        .fall_tick (fall_tick)
    );

    sample_loader u_load (
        .clk         (clk),
        .rst_n       (rst_n),
        .pack        (pack),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .frame_start (frame_start),
        .ready       (ready),
        .full        (full),
        .underrun    (underrun),
        .left_smp    (left_smp),
        .right_smp   (right_smp)
    );

    slot_serializer u_ser (
        .clk         (clk),
        .rst_n       (rst_n),
        .std         (std),
        .pack        (pack),
        .fall_tick   (fall_tick),
        .full        (full),
        .left_smp    (left_smp),
        .right_smp   (right_smp),
        .frame_start (frame_start),
        .ws          (ws),
        .sd          (sd)
    );

endmodule

// File: tb/test_audio_ser_tx.sv
module test_audio_ser_tx;
    localparam int HALF = 4;
    localparam int NF   = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  std_sel = '0, pack_sel = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        ready, underrun, bclk, ws, sd;

    int n_chk = 0, n_bad = 0;
    int cyc = 0;
    int cur_std = 0, cur_pack = 0;
    bit rec_on = 0, prev_bclk = 0;
    int nrec = 0;
    bit rec_ws [0:255];
    bit rec_sd [0:255];
    int rec_cyc [0:255];

    audio_ser_tx #(.HALF_DIV(HALF)) i_audio_ser_tx (
        .clk(clk), .rst_n(rst_n), .std_sel(std_sel), .pack_sel(pack_sel),
        .wr_en(wr_en), .wr_data(wr_data), .ready(ready), .underrun(underrun),
        .bclk(bclk), .ws(ws), .sd(sd)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc++;

    always @(negedge clk) begin
        if (rec_on && bclk && !prev_bclk && nrec < 256) begin
            rec_ws[nrec]  = ws;
            rec_sd[nrec]  = sd;
            rec_cyc[nrec] = cyc;
            nrec++;
        end
        prev_bclk = bclk;
    end

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] smp(int i);
        return 32'(i + 1) * 32'h9E3779B9 + 32'(cur_std * 4 + cur_pack) * 32'h01000193;
    endfunction

    function automatic int slot_of(int pk);  return (pk == 0) ? 16 : 32; endfunction
    function automatic int dat_of(int pk);   return (pk == 2) ? 24 : ((pk == 3) ? 32 : 16); endfunction

    // bit g of the un-delayed stream, MSB-aligned or right-justified
    function automatic bit stream_bit(int g, bit lsb);
        int s, d, f, q, c, p, off;
        logic [31:0] v;
        s = slot_of(cur_pack); d = dat_of(cur_pack);
        f = g / (2 * s); q = g % (2 * s); c = q / s; p = q % s;
        v = smp(2 * f + c);
        off = lsb ? s - d : 0;
        if (p < off || p >= off + d) return 1'b0;
        return v[31 - (p - off)];
    endfunction

    function automatic bit exp_sd(int g);
        if (cur_std == 0) return (g == 0) ? 1'b0 : stream_bit(g - 1, 1'b0);
        return stream_bit(g, cur_std == 2);
    endfunction

    function automatic bit exp_ws(int g);
        int s = slot_of(cur_pack);
        int q = g % (2 * s);
        if (cur_std == 3) return q == 2 * s - 1;
        return q >= s;
    endfunction

    task automatic reset_dut();
        wr_en = 0; rst_n = 0; rec_on = 0;
        repeat (3) @(negedge clk);
        chk("R10", "reset bclk", bclk, 0);
        chk("R10", "reset ws", ws, 0);
        chk("R10", "reset sd", sd, 0);
        chk("R10", "reset ready", ready, 1);
        chk("R10", "reset underrun", underrun, 0);
        nrec = 0; prev_bclk = 0; rec_on = 1;
        rst_n = 1;
    endtask

    task automatic run_combo(int s, int k);
        int nw, total, idx, slot, target;
        string tag_sd;
        cur_std = s; cur_pack = k;
        std_sel = 2'(s); pack_sel = 2'(k);
        slot = slot_of(k);
        nw = (k >= 2) ? 2 : 1;
        total = (NF + 3) * 2 * nw;
        target = 1 + NF * 2 * slot;
        tag_sd = (s == 0) ? "R4" : (s == 1) ? "R5" : (s == 2) ? "R6" : "R7";
        reset_dut();
        idx = 0;
        while (nrec < target) begin
            if (ready && idx < total) begin
                logic [31:0] v = smp(idx / nw);
                wr_en = 1;
                wr_data = (idx % nw == 0) ? v[31:16] : v[15:0];
                idx++;
            end else begin
                wr_en = 0;
            end
            @(negedge clk);
        end
        wr_en = 0; rec_on = 0;
        chk("R10", "first record ws", rec_ws[0], 0);
        chk("R10", "first record sd", rec_sd[0], 0);
        chk("R10", "bclk period", rec_cyc[2] - rec_cyc[1], 2 * HALF);
        for (int g = 0; g < NF * 2 * slot; g++) begin
            chk((s == 3) ? "R7" : "R1", $sformatf("ws std%0d pack%0d bit%0d", s, k, g),
                rec_ws[g + 1], exp_ws(g));
            chk(tag_sd, $sformatf("sd std%0d pack%0d bit%0d (R2 R3 R8)", s, k, g),
                rec_sd[g + 1], exp_sd(g));
        end
        chk("R9", "no underrun when fed", underrun, 0);
    endtask

    task automatic directed_flow();
        logic [31:0] l_v, r_v;
        cur_std = 1; cur_pack = 0;
        std_sel = 2'd1; pack_sel = 2'd0;
        reset_dut();
        wr_en = 1; wr_data = 16'hA5C3; @(negedge clk);
        wr_data = 16'h0F1E; @(negedge clk);
        chk("R8", "ready low when frame held", ready, 0);
        while (!ready) begin
            wr_en = 1; wr_data = 16'hFFFF;
            @(negedge clk);
        end
        wr_en = 0;
        chk("R8", "ready back at frame start", ready, 1);
        while (nrec < 34) @(negedge clk);
        l_v = 32'hA5C3_0000; r_v = 32'h0F1E_0000;
        for (int g = 0; g < 32; g++) begin
            chk("R8", $sformatf("held frame bit%0d", g), rec_sd[g + 1],
                (g < 16) ? l_v[31 - g] : r_v[31 - (g - 16)]);
        end
        chk("R9", "underrun raised", underrun, 1);
        chk("R9", "starved frame sends zero", rec_sd[33], 0);
        wr_en = 1; wr_data = 16'h1234; @(negedge clk);
        wr_en = 0;
        chk("R9", "write clears underrun", underrun, 0);
        @(negedge clk);
        chk("R9", "underrun stays clear", underrun, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int s = 0; s < 4; s++)
            for (int k = 0; k < 4; k++)
                run_combo(s, k);
        directed_flow();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule